// File: doc/BRIEF.md
# Backplane Row Scheduler with Cascade Alignment

This block sets the backplane time sequence of a multiplexed segment display driver. On every backplane-slot tick it moves to the next row of a four-row display memory. The number of rows in the loop depends on the multiplex mode: one for static drive, two, three or four for the multiplexed modes. For the active row it forms the memory row to read, taking the output bank selection into account. It returns the segment on/off vector for that row, blanked while the blink generator is in its dark half. It also raises the indicator of the active backplane.

Several instances can share one open-drain, active-low alignment line. An instance pulls the line down for the whole of its last active backplane slot. An instance that sees the line low while it is not pulling jumps straight to its own last row, so every device in the cascade ends the frame together. A new multiplex mode is taken over only at a frame boundary, and the row loop then restarts at row 0.

Top module: `bp_row_sched`

## Requirements
- R1: After reset the block is in static mode at row 0: `row_idx`=0, `bp_active`=4'b0001, `sync_drive`=1, `rd_row`=0, no blanking.
- R2: The mode code on `mode_in` is 0 for static, 1 for two rows, 2 for three rows and 3 for four rows, so the loop length is code+1. Each `bp_tick` advances `row_idx` by one and wraps to 0 after row code. Without a tick, and with the line released, the row holds.
- R3: `mode_in` is sampled only on a tick that ends the frame, which is a tick while `row_idx` equals the last row of the current mode. That tick sets `row_idx` to 0. A change of `mode_in` in mid-frame leaves the running sequence unchanged until the frame ends.
- R4: `sync_drive` is 1 exactly while `row_idx` is the last row of the current mode.
- R5: If `sync_n_in` is low in a cycle where `sync_drive` is 0, then `row_idx` becomes the last row of the current mode on the next clock: 3, 2, 1 or 0. This jump takes priority over a tick in the same cycle. In static mode the line has no effect.
- R6: `bp_active` is one-hot, with bit `row_idx` set.
- R7: In static mode `rd_row` is 2 when `out_bank`=1 and 0 when `out_bank`=0. In two-row mode `rd_row` is `row_idx`+2 when `out_bank`=1 and `row_idx` otherwise. In the three-row and four-row modes `rd_row` equals `row_idx` and `out_bank` is ignored.
- R8: `blink_sel`=0 turns blinking off. For `blink_sel`=k with k from 1 to 3, the half period is H=BLINK_HALF·2^(k-1) ticks. Counting t ticks from the moment `blink_sel` leaves 0, the display is blanked when (t mod 2H) ≥ H.
- R9: `seg_state` equals `rd_data` in the same cycle while not blanked, and is all zeros while blanked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bp_tick | input | 1 | One-cycle pulse at each backplane slot boundary |
| mode_in | input | 2 | Requested multiplex mode (0 static, 1/2/3 = two/three/four rows) |
| out_bank | input | 1 | Output bank selection for static and two-row modes |
| blink_sel | input | 2 | Blink setting (0 off, 1..3 slow to slower) |
| sync_n_in | input | 1 | Level of the shared active-low alignment line |
| rd_data | input | NUM_SEG | Display memory data of row `rd_row` |
| rd_row | output | 2 | Display memory row to read |
| row_idx | output | 2 | Active backplane row |
| bp_active | output | 4 | One-hot active backplane indicator |
| seg_state | output | NUM_SEG | Segment on/off states for the active row |
| sync_drive | output | 1 | 1 = pull the alignment line low |

## Verification
The assertions assume that `sync_n_in` is the wired level of the line. That level includes this instance's own pull, so it is low whenever `sync_drive` is 1. They also assume that `bp_tick` is a single-cycle pulse and that `rd_data` is a combinational read of `rd_row`. The bench builds the line as the AND of its own released state, the DUT's pull and an external pull pulse, and it models the memory as a combinational array. When the blink setting changes, the bench always passes through 0 first, because R8 measures the blink phase from that point.

// File: rtl/bp_sched_pkg.sv
// Shared types of the backplane row scheduler.
// The mode code value is also the index of the last row in the loop.
package bp_sched_pkg;
    typedef enum logic [1:0] {
        MUX_STATIC = 2'd0,
        MUX_DUO    = 2'd1,
        MUX_TRI    = 2'd2,
        MUX_QUAD   = 2'd3
    } mux_mode_t;

    localparam int unsigned BP_COUNT = 4;
    localparam int unsigned ROW_W    = $clog2(BP_COUNT);
endpackage

// File: rtl/bp_row_counter.sv
// Row loop counter with frame-boundary mode update and cascade alignment.
// Assumes sync_n_in is the wired line level, including this instance's own pull.
module bp_row_counter
    import bp_sched_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bp_tick,
    input  logic [1:0]       mode_in,
    input  logic             sync_n_in,
    output logic [ROW_W-1:0] row_q,
    output mux_mode_t        mode_q,
    output logic             sync_drive
);
    logic at_last;

    // The last row index equals the mode code.
    assign at_last    = (row_q == ROW_W'(mode_q));
    assign sync_drive = at_last;

    // Advance, wrap with mode update, or jump to the last row on an external pull.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q  <= '0;
            mode_q <= MUX_STATIC;
        end else if (bp_tick && at_last) begin
            row_q  <= '0;
            mode_q <= mux_mode_t'(mode_in);
        end else if (!sync_n_in && !at_last) begin
            row_q  <= ROW_W'(mode_q);
        end else if (bp_tick) begin
            row_q  <= row_q + ROW_W'(1);
        end
    end
endmodule

// File: rtl/bp_bank_map.sv
// Maps the logical backplane row to the display memory row, applying the output bank.
// Banking exists only in static and two-row modes; other modes pass the row through.
module bp_bank_map
    import bp_sched_pkg::*;
(
    input  mux_mode_t        mode,
    input  logic [ROW_W-1:0] row,
    input  logic             out_bank,
    output logic [ROW_W-1:0] rd_row
);
    // Select the physical row for the current mode.
    always_comb begin
        case (mode)
            MUX_STATIC: rd_row = out_bank ? ROW_W'(2) : ROW_W'(0);
            MUX_DUO:    rd_row = {out_bank, row[0]};
            default:    rd_row = row;
        endcase
    end
endmodule

// File: rtl/bp_blink_gen.sv
// Blink phase generator counting backplane ticks.
// Half period is BLINK_HALF << (sel-1) ticks; sel = 0 holds the counter cleared.
module bp_blink_gen #(
    parameter int unsigned BLINK_HALF = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bp_tick,
    input  logic [1:0] blink_sel,
    output logic       blank
);
    localparam int unsigned CNT_W = $clog2(BLINK_HALF * 8 + 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] half;
    logic [CNT_W-1:0] period;

    // Half period for the chosen rate.
    always_comb begin
        case (blink_sel)
            2'd2:    half = CNT_W'(BLINK_HALF * 2);
            2'd3:    half = CNT_W'(BLINK_HALF * 4);
            default: half = CNT_W'(BLINK_HALF);
        endcase
        period = half << 1;
    end

    // Count ticks over one full blink period.
    always_ff @(posedge clk) begin
        if (!rst_n || blink_sel == 2'd0) begin
            cnt <= '0;
        end else if (bp_tick) begin
            cnt <= (cnt >= period - CNT_W'(1)) ? '0 : cnt + CNT_W'(1);
        end
    end

    assign blank = (blink_sel != 2'd0) && (cnt >= half);
endmodule

// File: rtl/bp_row_sched.sv
// Backplane row scheduler: row loop, bank mapping, blink gating and one-hot
// backplane indicator. Assumes rd_data is a combinational read of rd_row.
module bp_row_sched
    import bp_sched_pkg::*;
#(
    parameter int unsigned NUM_SEG    = 40,
    parameter int unsigned BLINK_HALF = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bp_tick,
    input  logic [1:0]          mode_in,
    input  logic                out_bank,
    input  logic [1:0]          blink_sel,
    input  logic                sync_n_in,
    input  logic [NUM_SEG-1:0]  rd_data,
    output logic [ROW_W-1:0]    rd_row,
    output logic [ROW_W-1:0]    row_idx,
    output logic [BP_COUNT-1:0] bp_active,
    output logic [NUM_SEG-1:0]  seg_state,
    output logic                sync_drive
);
    mux_mode_t mode_q;
    logic      blank;

    bp_row_counter u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .bp_tick   (bp_tick),
        .mode_in   (mode_in),
        .sync_n_in (sync_n_in),
        .row_q     (row_idx),
        .mode_q    (mode_q),
        .sync_drive(sync_drive)
    );

    bp_bank_map u_map (
        .mode    (mode_q),
        .row     (row_idx),
        .out_bank(out_bank),
        .rd_row  (rd_row)
    );

    bp_blink_gen #(.BLINK_HALF(BLINK_HALF)) u_blink (
        .clk      (clk),
        .rst_n    (rst_n),
        .bp_tick  (bp_tick),
        .blink_sel(blink_sel),
        .blank    (blank)
    );

    // One decoder bit per backplane.
    for (genvar g = 0; g < BP_COUNT; g++) begin : g_bp
        assign bp_active[g] = (row_idx == ROW_W'(g));
    end

    // Gate the row data with the blink phase.
    assign seg_state = blank ? '0 : rd_data;
endmodule

// File: rtl/bp_row_sched_chk.sv
// Checker for bp_row_sched, attached with bind. Assumes sync_n_in includes
// the instance's own pull and that bp_tick is a one-cycle pulse.
module bp_row_sched_chk #(
    parameter int unsigned NUM_SEG = 40
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bp_tick,
    input logic               sync_n_in,
    input logic               sync_drive,
    input logic [1:0]         row_idx,
    input logic [1:0]         rd_row,
    input logic [3:0]         bp_active,
    input logic [NUM_SEG-1:0] rd_data,
    input logic [NUM_SEG-1:0] seg_state
);
    // R6
    onehot_bp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(bp_active) == 1);

    // R2
    wrap_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_drive && bp_tick) |=> (row_idx == 2'd0));

    // R2
    row_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bp_tick && sync_n_in) |=> $stable(row_idx));

    // R5
    sync_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_n_in && !sync_drive) |=> sync_drive);

    // R7
    upper_rows_unbanked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (row_idx >= 2'd2) |-> (rd_row == row_idx));

    // R9
    seg_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_state & ~rd_data) == '0);
endmodule

bind bp_row_sched bp_row_sched_chk #(.NUM_SEG(NUM_SEG)) u_chk (.*);

// File: tb/bp_row_sched_tb.sv
`timescale 1ns/1ps
module bp_row_sched_tb;
    localparam int NSEG = 40;
    localparam int BH   = 2;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            bp_tick;
    logic [1:0]      mode_in;
    logic            out_bank;
    logic [1:0]      blink_sel;
    logic            sync_n_in;
    logic            ext_pull;
    logic [NSEG-1:0] rd_data;
    logic [1:0]      rd_row;
    logic [1:0]      row_idx;
    logic [3:0]      bp_active;
    logic [NSEG-1:0] seg_state;
    logic            sync_drive;
    logic [NSEG-1:0] ram [4];

    int errors = 0;
    int checks = 0;
    bit done   = 0;
    int exp_row, exp_mode, bt;

    always #2.5 clk = ~clk;

    bp_row_sched #(.NUM_SEG(NSEG), .BLINK_HALF(BH)) u_dut (
        .clk(clk), .rst_n(rst_n), .bp_tick(bp_tick), .mode_in(mode_in),
        .out_bank(out_bank), .blink_sel(blink_sel), .sync_n_in(sync_n_in),
        .rd_data(rd_data), .rd_row(rd_row), .row_idx(row_idx),
        .bp_active(bp_active), .seg_state(seg_state), .sync_drive(sync_drive)
    );

    always_comb rd_data = ram[rd_row];
    assign sync_n_in = ~(sync_drive | ext_pull);

    function automatic int half_of(int s);
        return BH << (s - 1);
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        int er;
        bit bl;
        logic [NSEG-1:0] es;
        if (exp_mode == 0)      er = out_bank ? 2 : 0;
        else if (exp_mode == 1) er = out_bank ? exp_row + 2 : exp_row;
        else                    er = exp_row;
        bl = (blink_sel != 0) && ((bt % (2 * half_of(blink_sel))) >= half_of(blink_sel));
        es = bl ? '0 : ram[er];
        chk($sformatf("%s R2 row_idx", tag), 64'(row_idx), 64'(exp_row));
        chk($sformatf("%s R6 bp_active", tag), 64'(bp_active), 64'(1) << exp_row);
        chk($sformatf("%s R4 sync_drive", tag), 64'(sync_drive), 64'(exp_row == exp_mode));
        chk($sformatf("%s R7 rd_row", tag), 64'(rd_row), 64'(er));
        chk($sformatf("%s R8 R9 seg_state", tag), 64'(seg_state), 64'(es));
    endtask

    // One clock with optional tick and external pull, reference update, then checks.
    task automatic step(bit t, bit e, string tag);
        @(negedge clk);
        bp_tick  = t;
        ext_pull = e;
        if (t && exp_row == exp_mode) begin
            exp_row  = 0;
            exp_mode = int'(mode_in);
        end else if (e && exp_row != exp_mode) begin
            exp_row = exp_mode;
        end else if (t) begin
            exp_row++;
        end
        if (t && blink_sel != 0) bt++;
        @(negedge clk);
        bp_tick  = 1'b0;
        ext_pull = 1'b0;
        check_all(tag);
    endtask

    task automatic settle(int m);
        mode_in = 2'(m);
        for (int i = 0; i < 10; i++) begin
            if (exp_mode == m && exp_row == 0) break;
            step(1'b1, 1'b0, "R3 settle");
        end
    endtask

    task automatic set_blink(int s);
        @(negedge clk);
        blink_sel = 2'd0;
        @(negedge clk);
        blink_sel = 2'(s);
        bt = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; bp_tick = 1'b0; mode_in = 2'd0; out_bank = 1'b0;
        blink_sel = 2'd0; ext_pull = 1'b0;
        for (int r = 0; r < 4; r++) ram[r] = {5{8'(8'h11 * (r + 1)) ^ 8'h5A}};
        exp_row = 0; exp_mode = 0; bt = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 reset");

        // Exhaustive mode x bank sweep of the row loop.
        for (int m = 0; m < 4; m++) begin
            for (int b = 0; b < 2; b++) begin
                mode_in  = 2'(m);
                out_bank = 1'(b);
                for (int i = 0; i < 12; i++) step(1'b1, 1'b0, "R2 R3 R7 sweep");
            end
        end
        out_bank = 1'b0;

        // Mode change in mid-frame waits for the frame end.
        settle(3);
        step(1'b1, 1'b0, "R3 pre");
        mode_in = 2'd1;
        step(1'b1, 1'b0, "R3 midframe");
        chk("R3 midframe row stays in four-row loop", 64'(row_idx), 64'd2);
        step(1'b1, 1'b0, "R3 midframe");
        step(1'b1, 1'b0, "R3 boundary");
        chk("R3 new mode starts at row 0", 64'(row_idx), 64'd0);
        step(1'b1, 1'b0, "R3 new loop");
        chk("R3 two-row loop last row drives", 64'(sync_drive), 64'd1);

        // External pull from every non-last row of every multiplexed mode.
        for (int m = 1; m < 4; m++) begin
            settle(m);
            for (int r = 0; r < m; r++) begin
                for (int i = 0; i < r; i++) step(1'b1, 1'b0, "R5 position");
                step(1'b0, 1'b1, "R5 jump");
                chk("R5 jump to last row", 64'(row_idx), 64'(m));
                step(1'b1, 1'b0, "R5 wrap");
            end
            step(1'b1, 1'b1, "R5 priority over tick");
            chk("R5 priority over tick", 64'(row_idx), 64'(m));
            step(1'b1, 1'b0, "R5 wrap");
        end
        settle(0);
        step(1'b0, 1'b1, "R5 static ignores line");
        chk("R5 static ignores line", 64'(row_idx), 64'd0);

        // Blink rates.
        settle(3);
        for (int s = 1; s < 4; s++) begin
            set_blink(s);
            for (int i = 0; i < 4 * half_of(s) + 1; i++) step(1'b1, 1'b0, "R8 blink");
        end
        set_blink(0);
        for (int i = 0; i < 6; i++) step(1'b1, 1'b0, "R8 blink off");

        // Same-cycle pass-through of memory data.
        @(negedge clk);
        ram[row_idx] = ram[row_idx] ^ 40'hF0F0_0F0F_33;
        #1;
        chk("R9 same-cycle data", 64'(seg_state), 64'(ram[row_idx]));

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule